// File: doc/BRIEF.md
# Prioritised Interrupt Pending Controller

This block collects fifteen single-cycle interrupt pulses, numbered 1 to 15, into a pending register. It presents the most urgent request that is not masked to a processor as a 4-bit level, together with the matching trap type. Software reaches the block over a simple 32-bit register bus with word addressing. Through that bus it reads the pending bits, reads and writes the mask, clears pending bits with one-hot strobes, and can inject requests through a force register. The force register works only while a separate test-enable bit is set.

The processor accepts a request by raising `ack_valid` with the level it is taking. The block always accepts an acknowledge and never stalls it, so there is no back-pressure path. The pending bit for that level drops one clock later, unless the same source pulses in that cycle. Source numbers are also priorities: 15 is the most urgent and 1 the least.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset the pending bits read 0 and the mask register reads 0x0000FFFE, so every source is masked. `irq_level` is 0, `irq_trap` is 0x00 and test-enable is off.
- R2: A one-cycle pulse on `src_pulse[n]` sets pending bit n. The pending register is at word address 0, with source n at bit n and bit 0 reading 0. The bit is visible from the next clock edge.
- R3: `irq_level` is the highest n whose pending bit is 1 and whose mask bit is 0. It is 0 when no source meets both conditions. It follows register state combinationally.
- R4: `irq_trap` is 0x10 plus `irq_level` while the level is non-zero, and 0x00 while it is zero.
- R5: A mask bit of 1 keeps its source out of `irq_level`, but a pulse on that source still sets the pending bit.
- R6: Writing the clear register (word address 2) removes pending bit n for each data bit n that is 1. Bits written as 0 leave their pending bit as it was. A source pulse in the same cycle keeps its bit set.
- R7: Writing the force register (word address 3) sets pending bit n for each data bit n that is 1. This happens only while test-enable is 1. Test-enable is bit 19 of the test register at word address 4. Otherwise the force write has no effect.
- R8: An acknowledge (`ack_valid`=1 with `ack_level`=n, n not 0) clears pending bit n at the next edge. A pulse on source n in the same cycle keeps the bit set.
- R9: The mask register (word address 1) reads back the value last written in bits 15:1, so a read-modify-write of one bit changes only that bit. Bit 0 reads 0.
- R10: Writes to the pending register have no effect. Reads of the clear, force and test registers, and of unused addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 15 | Source pulses, bit n is source n (indices 15:1) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Processor acknowledges a level |
| ack_level | input | 4 | Level being acknowledged |
| irq_level | output | 4 | Highest unmasked pending source, 0 if none |
| irq_trap | output | 8 | Trap type, 0x10 + level, or 0 |

## Verification
A wrong pending or mask bit shows on `irq_level` and `irq_trap` at the first sample after the faulty edge, because the encoder is combinational. It also shows on a read of address 0 or 1 in the same cycle. A test-enable flop that is stuck or inverted is only visible when a later force write does, or does not, change the pending bits. For that reason the forced sweep checks the pending readback after every injection. A set/clear ordering fault appears only when a pulse and a clear or acknowledge fall in the same cycle, so those collisions are driven on purpose.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // Word addresses on the register bus
  localparam int unsigned RA_PEND  = 0;
  localparam int unsigned RA_MASK  = 1;
  localparam int unsigned RA_CLR   = 2;
  localparam int unsigned RA_FORCE = 3;
  localparam int unsigned RA_TEST  = 4;

  // Trap type base added to a non-zero level
  localparam logic [7:0] TRAP_BASE = 8'h10;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_pend_pkg::*;
#(
  parameter int NSRC     = 15,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int TEST_BIT = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [NSRC:1]   pend_q,
  output logic [DW-1:0]   bus_rdata,
  output logic [NSRC:1]   mask_q,
  output logic [NSRC:1]   clr_bits,
  output logic [NSRC:1]   force_bits
);
  logic sel_mask, sel_clr, sel_force, sel_test;
  logic test_en_q;
  logic unused_wdata;

  assign sel_mask  = bus_we && (bus_addr == AW'(RA_MASK));
  assign sel_clr   = bus_we && (bus_addr == AW'(RA_CLR));
  assign sel_force = bus_we && (bus_addr == AW'(RA_FORCE));
  assign sel_test  = bus_we && (bus_addr == AW'(RA_TEST));

  assign unused_wdata = ^bus_wdata;

  // Mask starts all ones; test enable starts off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      test_en_q <= 1'b0;
    end else begin
      if (sel_mask) mask_q    <= bus_wdata[NSRC:1];
      if (sel_test) test_en_q <= bus_wdata[TEST_BIT];
    end
  end

  // One-hot strobes into the pending bank
  assign clr_bits   = sel_clr ? bus_wdata[NSRC:1] : '0;
  assign force_bits = (sel_force && test_en_q) ? bus_wdata[NSRC:1] : '0;

  // Readback: only pending and mask are visible
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(RA_PEND))
      bus_rdata = DW'({pend_q, 1'b0});
    else if (bus_addr == AW'(RA_MASK))
      bus_rdata = DW'({mask_q, 1'b0});
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC  = 15,
  parameter int LVL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_pulse,
  input  logic [NSRC:1]     clr_bits,
  input  logic [NSRC:1]     force_bits,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [NSRC:1]     pend_q
);
  for (genvar n = 1; n <= NSRC; n++) begin : g_bit
    logic set_n, drop_n, bit_q;

    assign set_n  = src_pulse[n] | force_bits[n];
    assign drop_n = clr_bits[n] | (ack_valid && (ack_level == LVL_W'(n)));

    // A new event outranks any removal in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (set_n)  bit_q <= 1'b1;
      else if (drop_n) bit_q <= 1'b0;
    end

    assign pend_q[n] = bit_q;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NSRC  = 15,
  parameter int LVL_W = 4
) (
  input  logic [NSRC:1]    pend_q,
  input  logic [NSRC:1]    mask_q,
  output logic [LVL_W-1:0] level
);
  always_comb begin
    level = '0;
    for (int n = 1; n <= NSRC; n++)
      if (pend_q[n] && !mask_q[n]) level = LVL_W'(n);
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int NSRC     = 15,
  parameter int DW       = 32,
  parameter int AW       = 4,
  parameter int TEST_BIT = 19,
  localparam int LVL_W   = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_pulse,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ack_valid,
  input  logic [LVL_W-1:0]  ack_level,
  output logic [LVL_W-1:0]  irq_level,
  output logic [7:0]        irq_trap
);
  logic [NSRC:1] pend_q, mask_q, clr_bits, force_bits;

  irq_bus_decode #(.NSRC(NSRC), .DW(DW), .AW(AW), .TEST_BIT(TEST_BIT)) u_dec (
    .clk, .rst_n, .bus_we, .bus_addr, .bus_wdata,
    .pend_q, .bus_rdata, .mask_q, .clr_bits, .force_bits
  );

  irq_pend_bank #(.NSRC(NSRC), .LVL_W(LVL_W)) u_bank (
    .clk, .rst_n, .src_pulse, .clr_bits, .force_bits,
    .ack_valid, .ack_level, .pend_q
  );

  irq_prio_enc #(.NSRC(NSRC), .LVL_W(LVL_W)) u_enc (
    .pend_q, .mask_q, .level(irq_level)
  );

  assign irq_trap = (irq_level == '0) ? 8'h00 : (TRAP_BASE + 8'(irq_level));
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk
  import irq_pend_pkg::*;
#(
  parameter int NSRC  = 15,
  parameter int DW    = 32,
  parameter int AW    = 4,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC:1]    src_pulse,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic             ack_valid,
  input logic [LVL_W-1:0] ack_level,
  input logic [LVL_W-1:0] irq_level,
  input logic [NSRC:1]    pend_q,
  input logic [NSRC:1]    mask_q
);
  logic [NSRC:0] src_ext, pend_ext, elig_ext;
  assign src_ext  = {src_pulse, 1'b0};
  assign pend_ext = {pend_q, 1'b0};
  assign elig_ext = {pend_q & ~mask_q, 1'b0};

  // R2
  src_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(RA_CLR)) |=>
      ((pend_q & $past(bus_wdata[NSRC:1]) & ~$past(src_pulse)) == '0));

  // R8
  ack_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_level != '0 && !src_ext[ack_level] &&
     !(bus_we && bus_addr == AW'(RA_FORCE))) |=> !pend_ext[$past(ack_level)]);

  // R3
  level_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> elig_ext[irq_level]);

  // R3
  none_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_ext >> irq_level) >> 1) == '0);
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ack_valid(ack_valid),
  .ack_level(ack_level), .irq_level(irq_level), .pend_q(pend_q), .mask_q(mask_q)
);

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:1] src_pulse = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0;
  logic [3:0]  ack_level = '0;
  logic [3:0]  irq_level;
  logic [7:0]  irq_trap;

  int vecs = 0;
  int errs = 0;
  bit reported = 0;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk, .rst_n, .src_pulse, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .ack_valid, .ack_level, .irq_level, .irq_trap
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk);
    src_pulse = m[15:1];
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic ack(input int l);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = 4'(l);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  function automatic int top_level(input logic [15:0] e);
    int r = 0;
    for (int n = 1; n <= 15; n++) if (e[n]) r = n;
    return r;
  endfunction

  function automatic logic [7:0] trap_of(input int l);
    return (l == 0) ? 8'h00 : 8'(8'h10 + l);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog: got hang expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    logic [15:0] acc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, d); chk("R1 pending", d, 32'h0);
    rd(1, d); chk("R1 mask", d, 32'h0000FFFE);
    chk("R1 level", 32'(irq_level), 32'h0);
    chk("R1 trap", 32'(irq_trap), 32'h0);
    // R1 / R7 test enable off after reset: force has no effect
    wr(3, 32'h0000FFFE);
    rd(0, d); chk("R7 force blocked", d, 32'h0);

    // R2 R3 R4 R8: each source alone, unmasked
    wr(1, 32'h0);
    for (int n = 1; n <= 15; n++) begin
      pulse(16'(1 << n));
      rd(0, d); chk("R2 pend set", d, 32'(1 << n));
      chk("R3 level", 32'(irq_level), 32'(n));
      chk("R4 trap", 32'(irq_trap), 32'(trap_of(n)));
      ack(n);
      rd(0, d); chk("R8 ack clear", d, 32'h0);
      chk("R3 idle", 32'(irq_level), 32'h0);
    end

    // R5 masked sources still record
    wr(1, 32'h0000FFFE);
    acc = '0;
    for (int n = 1; n <= 15; n++) begin
      pulse(16'(1 << n));
      acc[n] = 1'b1;
      rd(0, d); chk("R5 pend records", d, 32'(acc));
      chk("R5 level masked", 32'(irq_level), 32'h0);
    end
    chk("R4 trap idle", 32'(irq_trap), 32'h0);

    // R6 clear with zeros, then partial clear
    wr(2, 32'h0);
    rd(0, d); chk("R6 zero clear", d, 32'h0000FFFE);
    wr(2, 32'h000000F0);
    rd(0, d); chk("R6 partial clear", d, 32'h0000FF0E);

    // R10 pending write ignored, write-only reads zero
    wr(0, 32'h0);
    rd(0, d); chk("R10 pend write ignored", d, 32'h0000FF0E);
    rd(2, d); chk("R10 clr read", d, 32'h0);
    rd(3, d); chk("R10 force read", d, 32'h0);
    rd(4, d); chk("R10 test read", d, 32'h0);
    rd(9, d); chk("R10 unused read", d, 32'h0);

    // R8 ack collides with a pulse on the same source
    wr(1, 32'h0);
    chk("R3 level 15", 32'(irq_level), 32'd15);
    @(negedge clk);
    ack_valid = 1'b1; ack_level = 4'd15; src_pulse = 15'(1 << 14);
    @(negedge clk);
    ack_valid = 1'b0; src_pulse = '0;
    rd(0, d); chk("R8 pulse wins", d, 32'h0000FF0E);
    ack(15);
    rd(0, d); chk("R8 ack 15", d, 32'h00007F0E);
    chk("R3 level 14", 32'(irq_level), 32'd14);

    // R6 clear collides with a pulse
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h00004000;
    src_pulse = 15'(1 << 13);
    @(negedge clk);
    bus_we = 1'b0; src_pulse = '0;
    rd(0, d); chk("R6 pulse wins", d, 32'h00007F0E);

    // R9 read-modify-write of the mask
    wr(1, 32'h00001230);
    rd(1, d); wr(1, d | 32'h0000_0020 | 32'h0000_8000);
    rd(1, d); chk("R9 rmw set", d, 32'h00009230);
    wr(1, d & ~32'h00001000);
    rd(1, d); chk("R9 rmw clear", d, 32'h00008230);
    wr(1, 32'hFFFFFFFF);
    rd(1, d); chk("R9 bit0 zero", d, 32'h0000FFFE);

    // R7 R3 R4 forced sweep with test enable on
    wr(4, 32'(1 << 19));
    for (int i = 0; i < 600; i++) begin
      logic [15:0] p, mk;
      int exp_l;
      p  = 16'((i * 40503 + 4660) ^ (i << 5)) & 16'hFFFE;
      mk = 16'((i * 23505) ^ (i >> 3)) & 16'hFFFE;
      wr(2, 32'h0000FFFF);
      wr(1, 32'(mk));
      wr(3, 32'(p));
      exp_l = top_level(p & ~mk);
      rd(0, d); chk("R7 forced pend", d, 32'(p));
      chk("R3 sweep level", 32'(irq_level), 32'(exp_l));
      chk("R4 sweep trap", 32'(irq_trap), 32'(trap_of(exp_l)));
    end

    // R7 test enable off again
    wr(4, 32'h0);
    wr(2, 32'h0000FFFF);
    wr(3, 32'h0000FFFF);
    rd(0, d); chk("R7 force off", d, 32'h0);

    report();
  end
endmodule